// File: doc/BRIEF.md
# Freezable Event Counter Bank

A performance-monitor block for a memory controller. It holds one 64-bit counter that counts clock cycles and ten 32-bit counters, each of which counts one event strobe picked by a 7-bit select code. All of its state sits in 32-bit registers behind a plain write port and a combinational read port. Software can stop any single counter through its own control register, or stop all of them at once through the global control register.

A counter overflows when its top bit goes from 0 to 1 because it incremented. The interrupt enable, the freeze-on-condition enable and that counter's own condition enable may all be 1 when this happens. In that case, at the clock edge that sets the top bit, the block also sets the global freeze bit in hardware and raises its interrupt level. All counting then stops. Software clears the interrupt in two steps: it clears the top bit of the counter that overflowed, and it clears the global freeze bit.

The register port has no back-pressure. A write is taken on every cycle in which `wr_en` is high, and `rd_data` always shows the register at `rd_addr` in the same cycle. The event strobes are level inputs that are sampled on every clock edge.

Top module: `evtmon_bank`

## Requirements
- R1: During and immediately after reset, all registers read 0 and `irq` is 0.
- R2: The global control register is at 0x40: bit 31 is the freeze-all bit, bit 30 is the interrupt enable and bit 29 is the freeze-on-condition enable. Local control for counter n is at 0x50+0x10*n: bit 31 is the counter's own freeze bit, bit 26 is its condition enable and bits 22:16 are its event select. Unimplemented bits read 0, and unmapped addresses read 0.
- R3: Counter 0 increments on every clock edge at which it is not frozen. Its low word is at 0x58 and its high word at 0x5C, and the carry from the low word passes into the high word.
- R4: Counter n (1..10) at 0x58+0x10*n increments by one on each edge at which it is not frozen and its selected strobe is high. A select code below 64 picks `evt_shared[code]`. A code of 64 or more picks bit (code-64) of that counter's 64-bit slice `evt_local[(n-1)*64 +: 64]`.
- R5: A counter whose own freeze bit is set holds its value. The other counters are not affected.
- R6: While the global freeze-all bit is set, every counter holds its value.
- R7: A write to a count word loads `wr_data` into that word, so a write of 0 clears it. The counter does not also increment on that edge.
- R8: Suppose an increment moves a counter's top bit from 0 to 1 while the interrupt enable, the freeze-on-condition enable and that counter's condition enable are all 1. Then, at that same edge, the freeze-all bit becomes 1 and `irq` becomes 1, and the counter stays at its new value.
- R9: If any one of those three enables is 0, an overflow does not raise `irq`, does not set freeze-all, and does not stop counting.
- R10: `irq` stays high until freeze-all has been cleared and the top bit of the overflowing counter has also been cleared. Clearing only one of the two leaves `irq` high.
- R11: The 64-bit counter overflows at bit 63. The carry out of a full low word is what moves the top bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read byte address |
| rd_data | output | 32 | Read data for `rd_addr`, same cycle |
| evt_shared | input | 64 | Event strobes selected by codes 0..63 |
| evt_local | input | 640 | Per-counter event strobes, 64 for each event counter, selected by codes 64..127 |
| irq | output | 1 | Overflow interrupt level |

## Verification
Most internal faults show up within a few cycles at `rd_data` or `irq`. A wrong freeze or enable state makes a windowed count read back one or more counts off, and the count keeps drifting while the bench waits. A wrong select decode makes a counter whose strobe is held high read 0, or makes a counter on an idle strobe read a nonzero count. A wrong overflow flag or interrupt state shows up either as `irq` missing three cycles after a preloaded counter crosses its top bit, or as `irq` staying high or dropping too early when the two clearing steps are applied in turn.

// File: rtl/evtmon_pkg.sv
package evtmon_pkg;
  localparam int REG_W    = 32;
  localparam int ADDR_W   = 8;
  localparam int SEL_W    = 7;
  localparam int BANK_SRC = 1 << (SEL_W - 1);
  localparam int NUM_EVT  = 10;
  localparam int CYC_W    = 64;
  localparam int EVT_W    = 32;

  localparam int G_FRZ_B  = 31;
  localparam int G_IE_B   = 30;
  localparam int G_CFE_B  = 29;
  localparam int L_FRZ_B  = 31;
  localparam int L_CE_B   = 26;
  localparam int L_SEL_LO = 16;

  localparam logic [ADDR_W-1:0] GCTL_OFS     = 8'h40;
  localparam int                SLICE_BASE   = 'h50;
  localparam int                SLICE_STRIDE = 'h10;
  localparam int                REL_LCTL     = 0;
  localparam int                REL_CNT_LO   = 8;
  localparam int                REL_CNT_HI   = 12;

  function automatic logic [ADDR_W-1:0] slice_addr(input int idx, input int rel);
    return ADDR_W'(SLICE_BASE + SLICE_STRIDE * idx + rel);
  endfunction
endpackage

// File: rtl/evtmon_counter.sv
module evtmon_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         ld_lo,
  input  logic         ld_hi,
  input  logic [31:0]  ld_data,
  output logic [W-1:0] cnt,
  output logic         ovf
);
  localparam int HI_W = (W > 32) ? (W - 32) : 1;

  logic [W-1:0] cnt_q;
  logic         busy;

  assign busy = ld_lo | ld_hi;

  generate
    if (W > 32) begin : g_wide
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (ld_lo)  cnt_q[31:0] <= ld_data;
        else if (ld_hi)  cnt_q[W-1:32] <= ld_data[HI_W-1:0];
        else if (inc)    cnt_q <= cnt_q + 1'b1;
      end
    end else begin : g_narrow
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt_q <= '0;
        else if (ld_lo)           cnt_q <= ld_data[W-1:0];
        else if (inc && !ld_hi)   cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate

  // top bit about to rise from an increment
  assign ovf = inc && !busy && !cnt_q[W-1] && (&cnt_q[W-2:0]);
  assign cnt = cnt_q;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !busy) |=> $stable(cnt_q));                              // R6
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !busy) |=> (cnt_q == $past(cnt_q) + 1'b1));               // R4
  AST_OVF_TOPBIT: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (cnt_q[W-1] && !$past(cnt_q[W-1])));                      // R8
endmodule

// File: rtl/evtmon_slice.sv
module evtmon_slice
  import evtmon_pkg::*;
#(
  parameter int IDX = 0,
  parameter int W   = 32,
  parameter bit CYC = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              freeze_all,
  input  logic [BANK_SRC-1:0] evt_shared,
  input  logic [BANK_SRC-1:0] evt_own,
  output logic [REG_W-1:0]  lctl_word,
  output logic [REG_W-1:0]  cnt_lo,
  output logic [REG_W-1:0]  cnt_hi,
  output logic              ovf_hit,
  output logic              top_bit
);
  logic             frz_q, ce_q;
  logic [SEL_W-1:0] sel_q;
  logic             hit_lctl, ld_lo, ld_hi, evt_pick, inc, ovf;
  logic [W-1:0]     cnt;

  assign hit_lctl = wr_en && (wr_addr == slice_addr(IDX, REL_LCTL));
  assign ld_lo    = wr_en && (wr_addr == slice_addr(IDX, REL_CNT_LO));
  assign ld_hi    = (W > 32) && wr_en && (wr_addr == slice_addr(IDX, REL_CNT_HI));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frz_q <= 1'b0;
      ce_q  <= 1'b0;
      sel_q <= '0;
    end else if (hit_lctl) begin
      frz_q <= wr_data[L_FRZ_B];
      ce_q  <= wr_data[L_CE_B];
      sel_q <= wr_data[L_SEL_LO +: SEL_W];
    end
  end

  // upper half of the code space selects this counter's own strobes
  assign evt_pick = sel_q[SEL_W-1] ? evt_own[sel_q[SEL_W-2:0]]
                                   : evt_shared[sel_q[SEL_W-2:0]];
  assign inc = !frz_q && !freeze_all && (CYC ? 1'b1 : evt_pick);

  evtmon_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(inc), .ld_lo(ld_lo), .ld_hi(ld_hi),
    .ld_data(wr_data), .cnt(cnt), .ovf(ovf)
  );

  assign lctl_word = {frz_q, 4'b0, ce_q, 3'b0, sel_q, 16'b0};
  assign cnt_lo    = cnt[31:0];
  generate
    if (W > 32) begin : g_hi
      assign cnt_hi = 32'(cnt[W-1:32]);
    end else begin : g_nohi
      assign cnt_hi = '0;
    end
  endgenerate
  assign ovf_hit = ovf & ce_q;
  assign top_bit = cnt[W-1];

  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((frz_q || freeze_all) && !ld_lo && !ld_hi) |=> $stable(cnt));    // R5
  AST_LOAD_NO_BUMP: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo |=> (cnt[31:0] == $past(wr_data)));                        // R7
endmodule

// File: rtl/evtmon_gctl.sv
module evtmon_gctl #(
  parameter int N = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hit,
  input  logic [2:0]   wr_bits,
  input  logic [N-1:0] ovf_hit,
  input  logic [N-1:0] top_bits,
  output logic         freeze_all,
  output logic [31:0]  gctl_word,
  output logic         irq
);
  logic         frz_q, ie_q, cfe_q, irq_q, trigger;
  logic [N-1:0] flag_q;

  assign trigger = ie_q && cfe_q && (|ovf_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frz_q <= 1'b0;
      ie_q  <= 1'b0;
      cfe_q <= 1'b0;
    end else begin
      if (wr_hit) begin
        ie_q  <= wr_bits[1];
        cfe_q <= wr_bits[0];
      end
      // hardware freeze wins over a same-cycle software write
      if (trigger)     frz_q <= 1'b1;
      else if (wr_hit) frz_q <= wr_bits[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else begin
      for (int n = 0; n < N; n++) begin
        if (trigger && ovf_hit[n]) flag_q[n] <= 1'b1;
        else if (!top_bits[n])     flag_q[n] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          irq_q <= 1'b0;
    else if (trigger)                    irq_q <= 1'b1;
    else if (!frz_q && (flag_q == '0))   irq_q <= 1'b0;
  end

  assign freeze_all = frz_q;
  assign irq        = irq_q;
  assign gctl_word  = {frz_q, ie_q, cfe_q, 29'b0};

  AST_OVF_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_q && cfe_q && (|ovf_hit)) |=> (frz_q && irq_q));             // R8
  AST_NO_GATE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ie_q && cfe_q) && !irq_q) |=> !irq_q);                       // R9
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && frz_q) |=> irq_q);                                     // R10
endmodule

// File: rtl/evtmon_bank.sv
module evtmon_bank
  import evtmon_pkg::*;
#(
  parameter int N_EVT = NUM_EVT
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [REG_W-1:0]         wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [REG_W-1:0]         rd_data,
  input  logic [BANK_SRC-1:0]      evt_shared,
  input  logic [N_EVT*BANK_SRC-1:0] evt_local,
  output logic                     irq
);
  localparam int N_ALL = N_EVT + 1;

  logic [REG_W-1:0] lctl_w [N_ALL];
  logic [REG_W-1:0] lo_w   [N_ALL];
  logic [REG_W-1:0] hi_w   [N_ALL];
  logic [N_ALL-1:0] ovf_hit, top_bits;
  logic             freeze_all;
  logic [REG_W-1:0] gctl_word;
  logic             gctl_hit;

  assign gctl_hit = wr_en && (wr_addr == GCTL_OFS);

  generate
    for (genvar i = 0; i < N_ALL; i++) begin : g_slice
      logic [BANK_SRC-1:0] own;
      if (i == 0) begin : g_cyc
        assign own = '0;
      end else begin : g_evt
        assign own = evt_local[(i-1)*BANK_SRC +: BANK_SRC];
      end
      evtmon_slice #(
        .IDX(i), .W((i == 0) ? CYC_W : EVT_W), .CYC(i == 0)
      ) u_slice (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .freeze_all(freeze_all),
        .evt_shared(evt_shared), .evt_own(own),
        .lctl_word(lctl_w[i]), .cnt_lo(lo_w[i]), .cnt_hi(hi_w[i]),
        .ovf_hit(ovf_hit[i]), .top_bit(top_bits[i])
      );
    end
  endgenerate

  evtmon_gctl #(.N(N_ALL)) u_gctl (
    .clk(clk), .rst_n(rst_n), .wr_hit(gctl_hit),
    .wr_bits({wr_data[G_FRZ_B], wr_data[G_IE_B], wr_data[G_CFE_B]}),
    .ovf_hit(ovf_hit), .top_bits(top_bits),
    .freeze_all(freeze_all), .gctl_word(gctl_word), .irq(irq)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == GCTL_OFS) rd_data = gctl_word;
    for (int i = 0; i < N_ALL; i++) begin
      if (rd_addr == slice_addr(i, REL_LCTL))   rd_data = lctl_w[i];
      if (rd_addr == slice_addr(i, REL_CNT_LO)) rd_data = lo_w[i];
      if (rd_addr == slice_addr(i, REL_CNT_HI)) rd_data = hi_w[i];
    end
  end

  AST_GFREEZE_HOLDS_C1: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_all && !wr_en) |=> $stable(lo_w[1]));                    // R6
endmodule

// File: tb/tb_evtmon_bank.sv
module tb_evtmon_bank;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [7:0]   wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic [7:0]   rd_addr = '0;
  logic [31:0]  rd_data;
  logic [63:0]  evt_shared = '0;
  logic [639:0] evt_local = '0;
  logic         irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sb_q[$];
  event req_ev;

  always #2ns clk = ~clk;

  evtmon_bank dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .evt_shared(evt_shared), .evt_local(evt_local), .irq(irq)
  );

  // monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      @(req_ev);
      #0.5ns;
      while (sb_q.size() > 0) begin
        exp_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        act = it.is_irq ? {31'b0, irq} : rd_data;
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s actual=0x%08h expected=0x%08h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic exp_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_t it;
    rd_addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    -> req_ev;
    #1ns;
  endtask

  task automatic exp_irq(input bit e, input string tag);
    exp_t it;
    it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
    sb_q.push_back(it);
    -> req_ev;
    #1ns;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] lctl(input int n); return 8'(8'h50 + 16*n); endfunction
  function automatic logic [7:0] cnt(input int n);  return 8'(8'h58 + 16*n); endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    cycles(3);
    // R1 reset state
    exp_rd(8'h40, 32'h0, "R1 global control in reset");
    exp_rd(lctl(1), 32'h0, "R1 local control in reset");
    exp_rd(cnt(1), 32'h0, "R1 counter in reset");
    exp_irq(1'b0, "R1 irq in reset");
    @(negedge clk);
    rst_n = 1'b1;
    exp_irq(1'b0, "R1 irq after reset");
    wr(8'h40, 32'h8000_0000);

    // R2 field layout and unmapped reads
    wr(lctl(3), 32'hFFFF_FFFF);
    exp_rd(lctl(3), 32'h847F_0000, "R2 local control fields");
    wr(8'h40, 32'hFFFF_FFFF);
    exp_rd(8'h40, 32'hE000_0000, "R2 global control fields");
    wr(8'h40, 32'h8000_0000);
    exp_rd(8'h44, 32'h0, "R2 unmapped read");

    // R3 R4 R5 R6 counting window
    wr(cnt(0), 0); wr(8'h5C, 0);
    for (int n = 1; n <= 4; n++) wr(cnt(n), 0);
    wr(lctl(1), 32'h000C_0000);     // shared code 12
    wr(lctl(2), 32'h0045_0000);     // local code 69 -> own bit 5
    wr(lctl(3), 32'h000D_0000);     // shared code 13, idle
    wr(lctl(4), 32'h800C_0000);     // code 12 but locally frozen
    evt_shared[12] = 1'b1;
    evt_local[64 + 5] = 1'b1;
    wr(8'h40, 32'h0);
    cycles(19);
    wr(8'h40, 32'h8000_0000);
    cycles(5);
    exp_rd(cnt(0), 32'd20, "R3 cycle count low word");
    exp_rd(8'h5C, 32'd0, "R3 cycle count high word");
    exp_rd(cnt(1), 32'd20, "R4 shared select count");
    exp_rd(cnt(2), 32'd20, "R4 local select count");
    exp_rd(cnt(3), 32'd0, "R4 idle select count");
    exp_rd(cnt(4), 32'd0, "R5 locally frozen counter");
    cycles(10);
    exp_rd(cnt(1), 32'd20, "R6 global freeze holds");

    // R7 load while counting
    wr(8'h40, 32'h0);
    wr(cnt(0), 32'd100);
    exp_rd(cnt(0), 32'd100, "R7 load without increment ctr0");
    wr(cnt(1), 32'h55);
    exp_rd(cnt(1), 32'h55, "R7 load without increment ctr1");
    wr(cnt(2), 32'h0);
    exp_rd(cnt(2), 32'h0, "R7 write zero clears");
    wr(8'h40, 32'h8000_0000);

    // R9 overflow with interrupt enable off
    wr(lctl(1), 32'h040C_0000);
    wr(cnt(1), 32'h7FFF_FFFE);
    wr(8'h40, 32'h2000_0000);
    cycles(4);
    exp_rd(8'h40, 32'h2000_0000, "R9 no hardware freeze");
    exp_irq(1'b0, "R9 no irq");
    wr(8'h40, 32'h8000_0000);
    exp_rd(cnt(1), 32'h8000_0003, "R9 counting continued");

    // R8 overflow with all enables
    wr(cnt(1), 32'h7FFF_FFFE);
    wr(8'h40, 32'h6000_0000);
    cycles(3);
    exp_irq(1'b1, "R8 irq raised");
    exp_rd(8'h40, 32'hE000_0000, "R8 hardware freeze set");
    exp_rd(cnt(1), 32'h8000_0000, "R8 counter stopped at top");
    cycles(5);
    exp_rd(cnt(1), 32'h8000_0000, "R8 still frozen");

    // R10 two-step clear
    wr(cnt(1), 32'h0);
    cycles(3);
    exp_irq(1'b1, "R10 irq holds while frozen");
    wr(8'h40, 32'h6000_0000);
    cycles(3);
    exp_irq(1'b0, "R10 irq cleared");

    // R11 64-bit overflow through the carry
    wr(8'h40, 32'h8000_0000);
    wr(lctl(1), 32'h000C_0000);
    wr(lctl(0), 32'h0400_0000);
    wr(cnt(0), 32'hFFFF_FFFE);
    wr(8'h5C, 32'h7FFF_FFFF);
    wr(8'h40, 32'h6000_0000);
    cycles(3);
    exp_irq(1'b1, "R11 irq on bit 63");
    exp_rd(8'h5C, 32'h8000_0000, "R11 high word");
    exp_rd(cnt(0), 32'h0, "R11 low word");

    cycles(2);
    done = 1'b1;
    summary();
  end
endmodule